// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

A small accumulator machine with a 4-bit datapath and a 16-entry address space. It holds a program counter, an opcode register, an argument register, an accumulator and three status flags: carry, zero and negative. Program words and data values are kept in two internal 16-entry arrays. A loader fills them through a write port, normally while reset is held.

Every instruction takes two clock cycles. In the fetch cycle the core drives the program counter on the address bus. At the end of that cycle it latches the opcode and argument, and it refreshes the flags from the accumulator. In the execute cycle the argument is on the address bus and the instruction takes effect. The data bus always shows the data array entry at the address-bus value. An exec-phase output tells the two cycles apart. A step counter counts completed instructions, so a testbench can stop after a fixed number of them.

Top module: `acc4_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, opcode and argument registers, all three flags, any pending store, the step counter and the phase. Memory contents are kept.
- R2: The core alternates between fetch cycles (`exec_phase`=0, `addr_bus` = program counter) and execute cycles (`exec_phase`=1, `addr_bus` = instruction argument). `data_bus` equals the data array entry at `addr_bus`.
- R3: An instruction word carries the opcode in bits [7:4] and the argument in bits [3:0]. Add-immediate (opcode 1) adds the argument to the accumulator. Add-memory (opcode 2) adds the data entry at the argument address. The accumulator keeps the sum modulo 16. NOP (opcode 0, and any unlisted opcode) leaves the accumulator unchanged.
- R4: Subtract-immediate (opcode 3) and subtract-memory (opcode 4) compute accumulator + (operand XOR 15) + 1 through the same 5-bit adder, and the result is kept modulo 16.
- R5: The pending carry takes bit 4 of the unwrapped 5-bit adder result. It changes only when that 5-bit result differs from the current accumulator; otherwise it keeps its value.
- R6: At each fetch edge the flags load from the committed accumulator. Zero is set when the accumulator is 0, and a sum of 16 wraps to 0. Negative equals bit 3. Carry takes the pending carry. The new flags are visible during the following execute cycle.
- R7: Store (opcode 5) records the argument address and the accumulator in the execute cycle. The array is written at the next fetch edge, so the old value is still on `data_bus` during that fetch cycle.
- R8: The program end is one past the address of the most recent program-array load. A fetch at or beyond the end executes a NOP with argument 0.
- R9: The program counter changes only at execute edges. It advances by one modulo 16 unless a jump is taken to a different address. A taken jump to its own address also advances by one.
- R10: Jump (opcode 6) always loads the argument into the program counter. Jump-if-zero (7), jump-if-carry (8) and jump-if-negative (9) do so only when the matching flag is set.
- R11: The step counter increments once at each execute edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_prog_en | input | 1 | Write `ld_word` to the program array at `ld_addr` |
| ld_data_en | input | 1 | Write `ld_word[3:0]` to the data array at `ld_addr` |
| ld_addr | input | 4 | Load address |
| ld_word | input | 8 | Load value |
| exec_phase | output | 1 | 1 in execute cycles, 0 in fetch cycles |
| addr_bus | output | 4 | Program counter in fetch, argument in execute |
| data_bus | output | 4 | Data array entry at `addr_bus` |
| pc | output | 4 | Program counter |
| acc | output | 4 | Accumulator |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| step_cnt | output | 16 | Completed instruction count |

## Verification
Two programs are run. The first chains additions and subtractions through a wrap to 16, an add of zero that must leave the carry untouched, a store followed by a read of the same address, and a run past the program end onto a preloaded word that must be ignored. The second exercises each jump both taken and not taken, a jump to its own address, and a store whose target is fetched next, so that the old data value must show during fetch and the new one during execute. It then continues through the NOP region until the program counter wraps back to address 0. During every execute cycle the program counter, accumulator, flags, step count and bus values are compared with hand-derived expectations.

// File: rtl/acc4_pkg.sv
package acc4_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'd0,
        OP_ADDI = 4'd1,
        OP_ADDM = 4'd2,
        OP_SUBI = 4'd3,
        OP_SUBM = 4'd4,
        OP_STA  = 4'd5,
        OP_JMP  = 4'd6,
        OP_JZ   = 4'd7,
        OP_JC   = 4'd8,
        OP_JN   = 4'd9
    } opcode_e;

endpackage

// File: rtl/acc4_ram.sv
module acc4_ram #(
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/acc4_addsub.sv
module acc4_addsub #(
    parameter int W = 4
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);
    logic [W-1:0] b_eff;

    // subtraction reuses the adder: invert operand, inject carry-in
    assign b_eff = sub ? ~b : b;
    assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

endmodule

// File: rtl/acc4_core.sv
module acc4_core #(
    parameter int W  = 4,
    parameter int SW = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ld_prog_en,
    input  logic                         ld_data_en,
    input  logic [W-1:0]                 ld_addr,
    input  logic [acc4_pkg::OPW+W-1:0]   ld_word,
    output logic                         exec_phase,
    output logic [W-1:0]                 addr_bus,
    output logic [W-1:0]                 data_bus,
    output logic [W-1:0]                 pc,
    output logic [W-1:0]                 acc,
    output logic                         flag_c,
    output logic                         flag_z,
    output logic                         flag_n,
    output logic [SW-1:0]                step_cnt
);
    import acc4_pkg::*;

    localparam int IW = OPW + W;

    typedef struct packed {
        logic [W-1:0]   pc;
        logic [W-1:0]   acc;
        logic [OPW-1:0] ir;
        logic [W-1:0]   dr;
        logic           c;
        logic           z;
        logic           n;
        logic           cnx;
        logic           exec;
        logic           pend_v;
        logic [W-1:0]   pend_a;
        logic [W-1:0]   pend_d;
        logic [W:0]     plen;
        logic [SW-1:0]  step;
    } core_s;

    core_s q, d;

    logic          im_we;
    logic [IW-1:0] im_rdata;
    logic          dm_we;
    logic [W-1:0]  dm_waddr;
    logic [W-1:0]  dm_wdata;
    logic [W-1:0]  dm_rdata;
    logic          is_sub;
    logic          is_mem;
    logic [W-1:0]  alu_b;
    logic [W:0]    alu_sum;
    logic          take;
    logic [W:0]    ld_end;

    assign addr_bus = q.exec ? q.dr : q.pc;

    acc4_ram #(.WIDTH(IW), .AW(W)) u_prog (
        .clk   (clk),
        .we    (im_we),
        .waddr (ld_addr),
        .wdata (ld_word),
        .raddr (q.pc),
        .rdata (im_rdata)
    );

    acc4_ram #(.WIDTH(W), .AW(W)) u_data (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (addr_bus),
        .rdata (dm_rdata)
    );

    assign is_sub = (q.ir == OP_SUBI) || (q.ir == OP_SUBM);
    assign is_mem = (q.ir == OP_ADDM) || (q.ir == OP_SUBM);
    assign alu_b  = is_mem ? dm_rdata : q.dr;
    assign ld_end = {1'b0, ld_addr} + (W+1)'(1);

    acc4_addsub #(.W(W)) u_alu (
        .sub (is_sub),
        .a   (q.acc),
        .b   (alu_b),
        .sum (alu_sum)
    );

    always_comb begin
        case (q.ir)
            OP_JMP:  take = 1'b1;
            OP_JZ:   take = q.z;
            OP_JC:   take = q.c;
            OP_JN:   take = q.n;
            default: take = 1'b0;
        endcase
    end

    always_comb begin
        d        = q;
        im_we    = ld_prog_en;
        dm_we    = 1'b0;
        dm_waddr = ld_addr;
        dm_wdata = ld_word[W-1:0];

        // loader has priority over the deferred store
        if (ld_data_en) begin
            dm_we = 1'b1;
        end else if (!rst && !q.exec && q.pend_v) begin
            dm_we    = 1'b1;
            dm_waddr = q.pend_a;
            dm_wdata = q.pend_d;
        end

        if (rst) begin
            d      = '0;
            d.plen = ld_prog_en ? ld_end : '0;
        end else begin
            if (ld_prog_en) begin
                d.plen = ld_end;
            end
            if (!q.exec) begin
                // fetch edge: commit store, refresh flags, latch instruction
                d.pend_v = 1'b0;
                d.z      = (q.acc == '0);
                d.n      = q.acc[W-1];
                d.c      = q.cnx;
                if ({1'b0, q.pc} < q.plen) begin
                    d.ir = im_rdata[IW-1:W];
                    d.dr = im_rdata[W-1:0];
                end else begin
                    d.ir = OP_NOP;
                    d.dr = '0;
                end
                d.exec = 1'b1;
            end else begin
                // execute edge
                case (q.ir)
                    OP_ADDI, OP_ADDM, OP_SUBI, OP_SUBM: begin
                        d.acc = alu_sum[W-1:0];
                        if (alu_sum != {1'b0, q.acc}) begin
                            d.cnx = alu_sum[W];
                        end
                    end
                    OP_STA: begin
                        d.pend_v = 1'b1;
                        d.pend_a = q.dr;
                        d.pend_d = q.acc;
                    end
                    default: ;
                endcase
                if (take && (q.dr != q.pc)) begin
                    d.pc = q.dr;
                end else begin
                    d.pc = q.pc + W'(1);
                end
                d.step = q.step + SW'(1);
                d.exec = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign exec_phase = q.exec;
    assign data_bus   = dm_rdata;
    assign pc         = q.pc;
    assign acc        = q.acc;
    assign flag_c     = q.c;
    assign flag_z     = q.z;
    assign flag_n     = q.n;
    assign step_cnt   = q.step;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q.pc == '0 && q.acc == '0 && !q.c && !q.z && !q.n &&
                 !q.pend_v && q.step == '0 && !q.exec));

    // R2
    exec_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        !q.exec |=> q.exec);

    // R2
    fetch_follows_exec_chk: assert property (@(posedge clk) disable iff (rst)
        q.exec |=> !q.exec);

    // R7
    store_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (!q.exec && q.pend_v) |=> !q.pend_v);

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !q.exec |=> $stable(q.pc));

    // R11
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        q.exec |=> q.step == $past(q.step) + SW'(1));

    // R3
    nop_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (q.exec && q.ir == OP_NOP) |=> $stable(q.acc));

endmodule

// File: tb/acc4_core_bench.sv
module acc4_core_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_prog_en = 1'b0;
    logic        ld_data_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [7:0]  ld_word = '0;
    logic        exec_phase;
    logic [3:0]  addr_bus;
    logic [3:0]  data_bus;
    logic [3:0]  pc;
    logic [3:0]  acc;
    logic        flag_c;
    logic        flag_z;
    logic        flag_n;
    logic [15:0] step_cnt;

    int chks = 0;
    int errs = 0;
    logic arm_f10 = 1'b0;

    typedef struct {
        int    pc_e;
        int    acc_e;
        int    c_e;
        int    z_e;
        int    n_e;
        int    st_e;
        int    ab_e;
        int    db_e;
        string tag;
    } exp_t;

    exp_t sb[$];

    acc4_core u_acc4_core (
        .clk        (clk),
        .rst        (rst),
        .ld_prog_en (ld_prog_en),
        .ld_data_en (ld_data_en),
        .ld_addr    (ld_addr),
        .ld_word    (ld_word),
        .exec_phase (exec_phase),
        .addr_bus   (addr_bus),
        .data_bus   (data_bus),
        .pc         (pc),
        .acc        (acc),
        .flag_c     (flag_c),
        .flag_z     (flag_z),
        .flag_n     (flag_n),
        .step_cnt   (step_cnt)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        chks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int p, int a, int c, int z, int n, int st, int ab, int db, string tag);
        exp_t e;
        e.pc_e = p; e.acc_e = a; e.c_e = c; e.z_e = z; e.n_e = n;
        e.st_e = st; e.ab_e = ab; e.db_e = db; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic load(logic prog, int addr, int word);
        @(negedge clk);
        ld_prog_en = prog;
        ld_data_en = !prog;
        ld_addr    = 4'(addr);
        ld_word    = 8'(word);
    endtask

    task automatic release_run();
        @(negedge clk);
        ld_prog_en = 1'b0;
        ld_data_en = 1'b0;
        rst        = 1'b0;
    endtask

    task automatic drain();
        for (int n = 0; n < 400 && sb.size() != 0; n++) begin
            @(negedge clk);
        end
        if (sb.size() != 0) begin
            chks++;
            errs++;
            $display("FAIL R2 drain: actual=%0d expected=0 items left", sb.size());
        end
    endtask

    task automatic check_reset();
        check("R1", "pc", int'(pc), 0);
        check("R1", "acc", int'(acc), 0);
        check("R1", "flags", int'({flag_c, flag_z, flag_n}), 0);
        check("R1", "step", int'(step_cnt), 0);
        check("R1", "phase", int'(exec_phase), 0);
    endtask

    // monitor: compare one expected item per execute cycle
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!rst && exec_phase && sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "pc", int'(pc), e.pc_e);
            check(e.tag, "acc", int'(acc), e.acc_e);
            check("R5", "carry", int'(flag_c), e.c_e);
            check("R6", "zero", int'(flag_z), e.z_e);
            check("R6", "negative", int'(flag_n), e.n_e);
            check("R11", "step", int'(step_cnt), e.st_e);
            check("R2", "addr_bus", int'(addr_bus), e.ab_e);
            if (e.db_e >= 0) check(e.tag, "data_bus", int'(data_bus), e.db_e);
        end
        if (!rst && !exec_phase && arm_f10 && pc == 4'd10) begin
            // R7: deferred store not yet visible during fetch
            check("R7", "fetch data_bus", int'(data_bus), 3);
            arm_f10 = 1'b0;
        end
    end

    initial begin
        #(CLK_P*100000);
        chks++;
        errs++;
        $display("FAIL R2 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check_reset();

        // program A: arithmetic, carry rule, store, past-end NOP
        load(1'b0, 10, 3);
        load(1'b0, 11, 0);
        load(1'b1, 9, 8'h11);   // beyond end once later words load
        load(1'b1, 0, 8'h15);   // ADDI 5
        load(1'b1, 1, 8'h1C);   // ADDI 12
        load(1'b1, 2, 8'h10);   // ADDI 0
        load(1'b1, 3, 8'h4A);   // SUBM 10
        load(1'b1, 4, 8'h3E);   // SUBI 14
        load(1'b1, 5, 8'h19);   // ADDI 9
        load(1'b1, 6, 8'h5B);   // STA 11
        load(1'b1, 7, 8'h0B);   // NOP 11
        load(1'b1, 8, 8'h2B);   // ADDM 11
        push(0, 0, 0, 1, 0, 0, 5, -1, "R3");
        push(1, 5, 0, 0, 0, 1, 12, -1, "R3");
        push(2, 1, 1, 0, 0, 2, 0, -1, "R3");
        push(3, 1, 1, 0, 0, 3, 10, 3, "R5");
        push(4, 14, 0, 0, 1, 4, 14, -1, "R4");
        push(5, 0, 1, 1, 0, 5, 9, -1, "R4");
        push(6, 9, 0, 0, 1, 6, 11, 0, "R7");
        push(7, 9, 0, 0, 1, 7, 11, 9, "R7");
        push(8, 9, 0, 0, 1, 8, 11, 9, "R3");
        push(9, 2, 1, 0, 0, 9, 0, -1, "R8");
        push(10, 2, 1, 0, 0, 10, 0, -1, "R8");
        release_run();
        drain();

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset();

        // program B: jumps, self-jump, deferred store on fetch, wrap
        load(1'b1, 0, 8'h1F);   // ADDI 15
        load(1'b1, 1, 8'h94);   // JN 4
        load(1'b1, 2, 8'h11);
        load(1'b1, 3, 8'h11);
        load(1'b1, 4, 8'h11);   // ADDI 1
        load(1'b1, 5, 8'h75);   // JZ 5 (self)
        load(1'b1, 6, 8'h88);   // JC 8
        load(1'b1, 7, 8'h13);
        load(1'b1, 8, 8'h16);   // ADDI 6
        load(1'b1, 9, 8'h5A);   // STA 10
        load(1'b1, 10, 8'h0A);  // NOP 10
        load(1'b1, 11, 8'h70);  // JZ 0
        push(0, 0, 0, 1, 0, 0, 15, -1, "R3");
        push(1, 15, 0, 0, 1, 1, 4, -1, "R10");
        push(4, 15, 0, 0, 1, 2, 1, -1, "R10");
        push(5, 0, 1, 1, 0, 3, 5, -1, "R5");
        push(6, 0, 1, 1, 0, 4, 8, -1, "R9");
        push(8, 0, 1, 1, 0, 5, 6, -1, "R10");
        push(9, 6, 0, 0, 0, 6, 10, 3, "R7");
        push(10, 6, 0, 0, 0, 7, 10, 6, "R7");
        push(11, 6, 0, 0, 0, 8, 0, -1, "R10");
        for (int k = 12; k < 16; k++) begin
            push(k, 6, 0, 0, 0, k - 3, 0, -1, "R8");
        end
        push(0, 6, 0, 0, 0, 13, 15, -1, "R9");
        push(1, 5, 1, 0, 0, 14, 4, -1, "R5");
        push(2, 5, 1, 0, 0, 15, 1, -1, "R10");
        arm_f10 = 1'b1;
        release_run();
        drain();
        if (arm_f10) begin
            chks++;
            errs++;
            $display("FAIL R7 fetch check: actual=not seen expected=seen");
        end

        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

endmodule